// File: doc/BRIEF.md
# Legacy BIOS Shadow Window Router

This block decides where each memory transaction that falls in the legacy firmware area just below 1 MB is sent. Five attribute-controlled segments are covered: four 16 KB extension segments and one 64 KB main firmware segment. Each segment has separate read and write enables, so a read and a write to the same address can go to different targets. A set enable sends that direction to main DRAM. A clear enable sends it to the downstream legacy I/O interface.

Routing also depends on the port that issued the request. Processor requests follow the attributes. Requests from an I/O-expansion-class port are overridden: writes always go to the legacy interface, and reads are completed internally. Requests from the accelerator complex port are master-aborted. Addresses outside both windows are marked as not claimed. Firmware can "shadow" the main segment by enabling DRAM reads and keeping DRAM writes disabled. Reads then come from the DRAM copy, while writes still reach the ROM.

Each decision is registered. It is offered on a one-hot output under a valid/ready handshake.

Top module: `bios_shadow_router`

## Requirements
- R1: After reset every read and write enable is clear, `rsp_valid` is low, and a processor read or write to the main segment routes to the legacy interface.
- R2: For a processor read in a claimed segment, the route is DRAM (`rsp_route` = 5'b00001) when that segment's read enable is set, and legacy (5'b00010) when it is clear.
- R3: For a processor write, the same choice is made from the segment's write enable, independently of its read enable. In shadow mode (read enable 1, write enable 0), reads go to DRAM and writes go to legacy.
- R4: The extension segments cover 0x0E0000–0x0EFFFF as four 16 KB segments numbered 0 to 3 in ascending address order. The main segment (number 4) covers 0x0F0000–0x0FFFFF.
- R5: `cfg_sel` 0, 1 and 2 each select one attribute byte. Segment 2k uses bit 0 as read enable and bit 1 as write enable. Segment 2k+1 uses bits 4 and 5 in the same way. Select 2 holds only segment 4 in bits 1:0. Every other bit reads as zero. A write with `cfg_sel` = 3 changes no attribute.
- R6: A write from port code 1 (I/O-expansion port) that hits a claimed segment routes to legacy (5'b00010) whatever the attributes are.
- R7: A read from port code 1 that hits a claimed segment completes internally (5'b00100).
- R8: Any request from port code 2 (accelerator complex) or port code 3 (reserved) that hits a claimed segment is master-aborted (5'b01000).
- R9: A request outside 0x0E0000–0x0FFFFF from any port is marked not claimed (5'b10000).
- R10: While `rsp_valid` is high, exactly one bit of `rsp_route` is set.
- R11: `req_ready` is high exactly when no decision is pending or the pending one is being taken. A pending decision stays unchanged while `rsp_ready` is low.
- R12: A request accepted in the same cycle as an attribute write is routed with the old attributes. Requests accepted after that cycle use the new attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Attribute byte write strobe |
| cfg_sel | input | 2 | Attribute byte select |
| cfg_wdata | input | 8 | Attribute byte write data |
| cfg_rdata | output | 8 | Attribute byte selected by `cfg_sel` |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_port | input | 2 | Source: 0 processor, 1 I/O-expansion, 2 accelerator, 3 reserved |
| rsp_valid | output | 1 | Routing decision present |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_route | output | 5 | One-hot: bit0 DRAM, bit1 legacy, bit2 internal, bit3 abort, bit4 not claimed |

## Verification
The assertions assume that, outside reset, `req_valid`, `req_write`, `req_port` and `rsp_ready` always carry defined values. They also assume the consumer does not expect a decision to change before it has taken it. The stimulus changes inputs only on falling edges, and holds `req_valid` for exactly one accepting edge per request. It drops `rsp_ready` only in the directed backpressure case, where a second request is held waiting until the first decision is taken.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

    localparam int EXT_SEGS  = 4;
    localparam int NSEG      = EXT_SEGS + 1;
    localparam int MAIN_IDX  = EXT_SEGS;
    localparam int ROUTE_W   = 5;
    localparam int CFG_W     = 8;
    localparam int SEL_W     = 2;
    localparam int NREG      = (NSEG + 1) / 2;

    typedef enum logic [1:0] {
        SRC_CPU   = 2'd0,
        SRC_IOX   = 2'd1,
        SRC_ACCEL = 2'd2,
        SRC_RSVD  = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        RT_DRAM      = 3'd0,
        RT_LEGACY    = 3'd1,
        RT_INTERNAL  = 3'd2,
        RT_ABORT     = 3'd3,
        RT_UNCLAIMED = 3'd4
    } route_e;

    typedef struct packed {
        logic wr_en;
        logic rd_en;
    } seg_attr_t;

    function automatic logic [ROUTE_W-1:0] route_onehot(input route_e r);
        logic [ROUTE_W-1:0] v;
        v = '0;
        v[r] = 1'b1;
        return v;
    endfunction

    function automatic route_e cpu_route(input seg_attr_t a, input logic wr);
        logic en;
        en = wr ? a.wr_en : a.rd_en;
        return en ? RT_DRAM : RT_LEGACY;
    endfunction

endpackage

// File: rtl/shadow_attr_regs.sv
module shadow_attr_regs
    import shadow_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  logic [SEL_W-1:0]            cfg_sel,
    input  logic [CFG_W-1:0]            cfg_wdata,
    output logic [CFG_W-1:0]            cfg_rdata,
    output seg_attr_t [NSEG-1:0]        attrs
);

    localparam int NIB = CFG_W / 2;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        localparam int REG_IDX = s / 2;
        localparam int LANE    = (s % 2) * NIB;
        seg_attr_t attr_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                attr_q <= '0;
            end else if (cfg_we && (int'(cfg_sel) == REG_IDX)) begin
                attr_q.rd_en <= cfg_wdata[LANE];
                attr_q.wr_en <= cfg_wdata[LANE+1];
            end
        end

        assign attrs[s] = attr_q;
    end

    always_comb begin
        cfg_rdata = '0;
        for (int s = 0; s < NSEG; s++) begin
            if (int'(cfg_sel) == s / 2) begin
                cfg_rdata[(s % 2) * NIB]     = attrs[s].rd_en;
                cfg_rdata[(s % 2) * NIB + 1] = attrs[s].wr_en;
            end
        end
    end

    // R5
    reserved_bits_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && ((cfg_wdata & 8'hCC) != 8'h00)) |=> ((cfg_rdata & 8'hCC) == 8'h00));

    // R5
    sel3_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_sel == 2'd3)) |=> (attrs == $past(attrs)));

    // R12
    attr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> (attrs == $past(attrs)));

endmodule

// File: rtl/shadow_decode.sv
module shadow_decode
    import shadow_pkg::*;
#(
    parameter int                 ADDR_W     = 32,
    parameter logic [ADDR_W-1:0]  EXT_BASE   = 32'h000E_0000,
    parameter int                 SEG_SHIFT  = 14,
    parameter int                 MAIN_SHIFT = 16
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  write,
    input  logic [1:0]            port,
    input  seg_attr_t [NSEG-1:0]  attrs,
    output route_e                route
);

    localparam logic [ADDR_W:0] EXT_LO  = {1'b0, EXT_BASE};
    localparam logic [ADDR_W:0] EXT_HI  = EXT_LO + (ADDR_W+1)'(EXT_SEGS << SEG_SHIFT);
    localparam logic [ADDR_W:0] MAIN_HI = EXT_HI + (ADDR_W+1)'(1 << MAIN_SHIFT);
    localparam int              IDX_W   = $clog2(EXT_SEGS);

    logic [ADDR_W:0]  a_ext;
    logic             in_ext;
    logic             in_main;
    logic [IDX_W-1:0] ext_idx;
    seg_attr_t        hit_attr;
    src_e             src;

    assign a_ext   = {1'b0, addr};
    assign in_ext  = (a_ext >= EXT_LO) && (a_ext < EXT_HI);
    assign in_main = (a_ext >= EXT_HI) && (a_ext < MAIN_HI);
    assign ext_idx = addr[SEG_SHIFT +: IDX_W];
    assign src     = src_e'(port);

    always_comb begin
        hit_attr = attrs[MAIN_IDX];
        if (in_ext) begin
            hit_attr = attrs[ext_idx];
        end
    end

    always_comb begin
        if (!(in_ext || in_main)) begin
            route = RT_UNCLAIMED;
        end else begin
            unique case (src)
                SRC_CPU: route = cpu_route(hit_attr, write);
                SRC_IOX: route = write ? RT_LEGACY : RT_INTERNAL;
                default: route = RT_ABORT;
            endcase
        end
    end

endmodule

// File: rtl/shadow_route_stage.sv
module shadow_route_stage
    import shadow_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  route_e             in_route,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [ROUTE_W-1:0] out_route
);

    logic   valid_q;
    route_e route_q;
    logic   take;

    assign in_ready = !valid_q || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            route_q <= RT_UNCLAIMED;
        end else begin
            if (take) begin
                valid_q <= 1'b1;
                route_q <= in_route;
            end else if (out_ready) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_route = route_onehot(route_q);

    // R10
    route_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_route) == 1));

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_route)));

    // R11
    stall_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: rtl/bios_shadow_router.sv
module bios_shadow_router
    import shadow_pkg::*;
#(
    parameter int                 ADDR_W     = 32,
    parameter logic [ADDR_W-1:0]  EXT_BASE   = 32'h000E_0000,
    parameter int                 SEG_SHIFT  = 14,
    parameter int                 MAIN_SHIFT = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    input  logic [1:0]         req_port,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [4:0]         rsp_route
);

    seg_attr_t [NSEG-1:0] attrs;
    route_e               dec_route;

    shadow_attr_regs u_attr (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .attrs     (attrs)
    );

    shadow_decode #(
        .ADDR_W     (ADDR_W),
        .EXT_BASE   (EXT_BASE),
        .SEG_SHIFT  (SEG_SHIFT),
        .MAIN_SHIFT (MAIN_SHIFT)
    ) u_dec (
        .addr  (req_addr),
        .write (req_write),
        .port  (req_port),
        .attrs (attrs),
        .route (dec_route)
    );

    shadow_route_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_route  (dec_route),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .out_route (rsp_route)
    );

    logic fire;
    assign fire = req_valid && req_ready;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> !rsp_valid);

    // R6
    iox_write_legacy_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && req_port == 2'd1 && req_write) |=> (rsp_route[1] || rsp_route[4]));

    // R7
    iox_read_internal_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && req_port == 2'd1 && !req_write) |=> (rsp_route[2] || rsp_route[4]));

    // R8
    accel_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && req_port[1]) |=> (rsp_route[3] || rsp_route[4]));

    // R2
    cpu_no_override_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && req_port == 2'd0) |=> (rsp_route[0] || rsp_route[1] || rsp_route[4]));

endmodule

// File: tb/sim_bios_shadow_router.sv
module sim_bios_shadow_router;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = 32'h0;
    logic        req_write = 1'b0;
    logic [1:0]  req_port = 2'd0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [4:0]  rsp_route;

    int checks = 0;
    int errors = 0;

    localparam logic [4:0] DRAM = 5'b00001, LEG = 5'b00010, INTC = 5'b00100,
                           ABT = 5'b01000, UNC = 5'b10000;

    always #10 clk = ~clk;

    bios_shadow_router u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
        .req_port(req_port), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_route(rsp_route)
    );

    // {addr, write, port, expected route}; attributes: sel0=0x21 sel1=0x13 sel2=0x01
    localparam int NV = 19;
    localparam logic [39:0] VEC [NV] = '{
        {32'h000E_0000, 1'b0, 2'd0, 5'b00001},  // R2 R4 seg0 read enabled
        {32'h000E_3FFF, 1'b1, 2'd0, 5'b00010},  // R3 R4 seg0 write disabled
        {32'h000E_4000, 1'b0, 2'd0, 5'b00010},  // R2 R4 seg1 read disabled
        {32'h000E_7FFF, 1'b1, 2'd0, 5'b00001},  // R3 R4 seg1 write enabled
        {32'h000E_8000, 1'b0, 2'd0, 5'b00001},  // R2 R4 seg2
        {32'h000E_BFFF, 1'b1, 2'd0, 5'b00001},  // R3 R4 seg2
        {32'h000E_C000, 1'b0, 2'd0, 5'b00001},  // R2 R4 seg3
        {32'h000E_FFFF, 1'b1, 2'd0, 5'b00010},  // R3 R4 seg3
        {32'h000F_0000, 1'b0, 2'd0, 5'b00001},  // R3 shadow read
        {32'h000F_FFFF, 1'b1, 2'd0, 5'b00010},  // R3 shadow write
        {32'h000D_FFFF, 1'b0, 2'd0, 5'b10000},  // R9 below window
        {32'h0010_0000, 1'b1, 2'd0, 5'b10000},  // R9 above window
        {32'h000E_8000, 1'b1, 2'd1, 5'b00010},  // R6 overrides DRAM write
        {32'h000F_0000, 1'b0, 2'd1, 5'b00100},  // R7
        {32'h000F_8000, 1'b1, 2'd2, 5'b01000},  // R8
        {32'h000E_4000, 1'b0, 2'd2, 5'b01000},  // R8
        {32'h0010_0000, 1'b0, 2'd2, 5'b10000},  // R9
        {32'h000C_0000, 1'b1, 2'd1, 5'b10000},  // R9
        {32'h000F_4000, 1'b0, 2'd3, 5'b01000}   // R8 reserved port
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] sel, input logic [7:0] exp, input string req);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        check(req, {24'h0, cfg_rdata}, {24'h0, exp});
    endtask

    task automatic send(input logic [31:0] a, input logic w, input logic [1:0] p);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_port = p;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic expect_route(input logic [4:0] exp, input string req);
        @(negedge clk);
        check(req, {27'h0, rsp_valid, rsp_route}, {27'h0, 1'b1, exp});
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
        rst = 1'b0;
        for (int s = 0; s < 3; s++) cfg_read(2'(s), 8'h00, "R1 attrs cleared");
        send(32'h000F_2000, 1'b0, 2'd0);
        expect_route(LEG, "R1 default main read");
        send(32'h000F_2000, 1'b1, 2'd0);
        expect_route(LEG, "R1 default main write");

        // R5 register layout and reserved bits
        cfg_write(2'd0, 8'hFF);
        cfg_read(2'd0, 8'h33, "R5 sel0 reserved bits zero");
        cfg_write(2'd2, 8'hFF);
        cfg_read(2'd2, 8'h03, "R5 sel2 upper nibble zero");
        cfg_write(2'd3, 8'hFF);
        cfg_read(2'd1, 8'h00, "R5 sel3 write ignored sel1");
        cfg_read(2'd3, 8'h00, "R5 sel3 reads zero");
        cfg_read(2'd0, 8'h33, "R5 sel3 write ignored sel0");
        cfg_write(2'd0, 8'h10);
        send(32'h000E_4000, 1'b0, 2'd0);
        expect_route(DRAM, "R5 bit4 is seg1 read enable");
        send(32'h000E_0000, 1'b0, 2'd0);
        expect_route(LEG, "R5 bit0 clear seg0");

        // table walk
        cfg_write(2'd0, 8'h21);
        cfg_write(2'd1, 8'h13);
        cfg_write(2'd2, 8'h01);
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][39:8], VEC[i][7], VEC[i][6:5]);
            expect_route(VEC[i][4:0], $sformatf("R2/R3/R4/R6-R9 vector %0d", i));
        end

        // R12: write and request accepted on the same edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 8'h00;
        req_valid = 1'b1; req_addr = 32'h000F_0000; req_write = 1'b0; req_port = 2'd0;
        @(posedge clk); #1;
        cfg_we = 1'b0; req_valid = 1'b0;
        expect_route(DRAM, "R12 same-cycle uses old attr");
        send(32'h000F_0000, 1'b0, 2'd0);
        expect_route(LEG, "R12 next request uses new attr");

        // R11 backpressure
        @(negedge clk);
        rsp_ready = 1'b0;
        send(32'h000E_0000, 1'b0, 2'd0);
        @(negedge clk);
        check("R11 ready low while stalled", {31'h0, req_ready}, 32'h0);
        check("R11 first decision", {27'h0, rsp_valid, rsp_route}, {27'h0, 1'b1, DRAM});
        req_valid = 1'b1; req_addr = 32'h000E_0000; req_write = 1'b0; req_port = 2'd1;
        @(negedge clk);
        check("R11 decision held", {27'h0, rsp_valid, rsp_route}, {27'h0, 1'b1, DRAM});
        rsp_ready = 1'b1;
        #1;
        check("R11 ready when taken", {31'h0, req_ready}, 32'h1);
        @(posedge clk); #1;
        req_valid = 1'b0;
        expect_route(INTC, "R11 R7 second request after stall");
        @(negedge clk);
        check("R11 idle after drain", {31'h0, rsp_valid}, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule